// File: doc/BRIEF.md
# Sanitising Table Base Register

This block is one 64-bit configuration register. It holds the base address and the memory attributes of an in-memory interrupt table. The table is either a property table or a pending table, and a build-time parameter picks which of the two the register serves. Software writes it through a simple write port. A write covers either one 32-bit half or the whole 64 bits. The stored value feeds the logic that later walks the table.

Each accepted write is first merged with the current contents. The merged 64-bit word then goes through a sanitiser before it is stored:

- Attribute encodings that the memory system cannot honour are replaced with supported ones.
- The bits reserved for the selected variant are forced to zero.

While the table-enable input is high, the register is frozen and every write is silently discarded. A program therefore cannot move the table under a running walker.

Top module: `tbase_reg`

## Requirements
- R1: After reset the stored value `base_o` is all zeros.
- R2: While `lock_i` is 1, a write (`wr_en_i` = 1) has no effect and `base_o` keeps its value.
- R3: A half write (`wr_full_i` = 0) places `wr_data_i[31:0]` into bits 31:0 when `wr_hi_i` = 0, or into bits 63:32 when `wr_hi_i` = 1. The other half keeps its stored value.
- R4: A full write (`wr_full_i` = 1) takes all 64 bits of `wr_data_i`, and `wr_hi_i` is ignored.
- R5: The shareability field at bits 11:10 is handled as follows: a value of 2 (outer) is stored as 1 (inner), and the values 0, 1 and 3 are stored unchanged.
- R6: The inner cacheability field at bits 9:7 is handled as follows: a value of 0 or 1 is stored as 3 (read-allocate write-back), and the values 2 and 4 to 7 are stored unchanged.
- R7: The outer cacheability field at bits 58:56 is handled as follows: a value of 0 (same as inner) or 1 (non-cacheable) is kept, and any other value is stored as 1.
- R8: In the property variant (`PEND_TABLE` = 0), bits 63:59, 55:48 and 6:5 of the stored value are always zero.
- R9: In the pending variant (`PEND_TABLE` = 1), bits 63, 61:59, 55:48, 15:12 and 6:0 of the stored value are always zero, and bit 62 is stored as written.
- R10: The sanitiser works on the merged 64-bit word, not on the written half alone. The result appears on `base_o` at the first clock edge after the write is presented, so an upper-half write also brings the lower half's attribute fields into their legal form.
- R11: Without a write, `base_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for one cycle |
| wr_hi_i | input | 1 | Half select for a 32-bit write (address bit 2) |
| wr_full_i | input | 1 | 1 = 64-bit write, 0 = 32-bit write |
| wr_data_i | input | 64 | Write data; a half write uses bits 31:0 |
| lock_i | input | 1 | Table enable; while high, writes are dropped |
| base_o | output | 64 | Stored, sanitised register value |

## Verification
The clocked assertions assume the following about the inputs:

- `wr_en_i`, `wr_hi_i`, `wr_full_i` and `lock_i` are known (not X) on every clock edge after reset.
- `lock_i` is held steady through the edge on which a write is sampled.

The bench meets these assumptions by driving every input on the falling edge only, and from defined values, including during the pseudo-random phase. The "other half unchanged" property covers only bits 31:12. Bits 11:0 of the lower half may legitimately be rewritten by the sanitiser on an upper-half write, and the stimulus exercises exactly that case from the reset value.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    localparam int REG_W  = 64;
    localparam int HALF_W = REG_W / 2;

    // attribute field positions
    localparam int SHR_LO  = 10;
    localparam int SHR_W   = 2;
    localparam int ICA_LO  = 7;
    localparam int ICA_W   = 3;
    localparam int OCA_LO  = 56;
    localparam int OCA_W   = 3;

    // encodings
    localparam logic [SHR_W-1:0] SHR_INNER = 2'd1;
    localparam logic [SHR_W-1:0] SHR_OUTER = 2'd2;
    localparam logic [ICA_W-1:0] CA_NCNB   = 3'd0;
    localparam logic [ICA_W-1:0] CA_NC     = 3'd1;
    localparam logic [ICA_W-1:0] CA_RAWB   = 3'd3;
    localparam logic [OCA_W-1:0] OCA_SAME  = 3'd0;

    typedef struct packed {
        logic [REG_W-1:0] val;
    } tbase_state_t;

    function automatic logic [REG_W-1:0] span(input int hi, input int lo);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < REG_W; i++) begin
            if (i >= lo && i <= hi) m[i] = 1'b1;
        end
        return m;
    endfunction

    // reserved bits, including the address bits 51:48 shared by both variants
    function automatic logic [REG_W-1:0] rsv_mask(input bit pend);
        logic [REG_W-1:0] m;
        m = span(51, 48) | span(55, 52);
        if (pend) begin
            m = m | span(63, 63) | span(61, 59) | span(15, 12) | span(6, 0);
        end else begin
            m = m | span(63, 59) | span(6, 5);
        end
        return m;
    endfunction

endpackage

// File: rtl/tbase_merge.sv
module tbase_merge
    import tbase_pkg::*;
(
    input  logic [REG_W-1:0] old_i,
    input  logic [REG_W-1:0] data_i,
    input  logic             hi_i,
    input  logic             full_i,
    output logic [REG_W-1:0] merged_o
);

    logic [HALF_W-1:0] lo_half;
    logic [HALF_W-1:0] up_half;

    always_comb begin
        if (full_i) begin
            lo_half = data_i[HALF_W-1:0];
            up_half = data_i[REG_W-1:HALF_W];
        end else if (hi_i) begin
            lo_half = old_i[HALF_W-1:0];
            up_half = data_i[HALF_W-1:0];
        end else begin
            lo_half = data_i[HALF_W-1:0];
            up_half = old_i[REG_W-1:HALF_W];
        end
        merged_o = {up_half, lo_half};
    end

endmodule

// File: rtl/tbase_sanitise.sv
module tbase_sanitise
    import tbase_pkg::*;
#(
    parameter bit PEND_TABLE = 1'b0
) (
    input  logic [REG_W-1:0] raw_i,
    output logic [REG_W-1:0] clean_o
);

    logic [REG_W-1:0] rsv;
    logic [SHR_W-1:0] shr_in, shr_out;
    logic [ICA_W-1:0] ica_in, ica_out;
    logic [OCA_W-1:0] oca_in, oca_out;
    logic [REG_W-1:0] fixed;

    generate
        if (PEND_TABLE) begin : g_pend
            assign rsv = rsv_mask(1'b1);
        end else begin : g_prop
            assign rsv = rsv_mask(1'b0);
        end
    endgenerate

    always_comb begin
        shr_in = raw_i[SHR_LO +: SHR_W];
        ica_in = raw_i[ICA_LO +: ICA_W];
        oca_in = raw_i[OCA_LO +: OCA_W];

        shr_out = (shr_in == SHR_OUTER) ? SHR_INNER : shr_in;
        ica_out = (ica_in == CA_NCNB || ica_in == CA_NC) ? CA_RAWB : ica_in;
        oca_out = (oca_in == OCA_SAME || oca_in == CA_NC) ? oca_in : CA_NC;

        fixed = raw_i;
        fixed[SHR_LO +: SHR_W] = shr_out;
        fixed[ICA_LO +: ICA_W] = ica_out;
        fixed[OCA_LO +: OCA_W] = oca_out;
        clean_o = fixed & ~rsv;
    end

    // R5/R6/R7: rewritten fields never carry an unsupported code
    always_comb begin
        assert_field_codes_R5: assert (clean_o[SHR_LO +: SHR_W] != SHR_OUTER);
        assert_inner_code_R6:  assert (clean_o[ICA_LO +: ICA_W] > CA_NC);
        assert_outer_code_R7:  assert (clean_o[OCA_LO +: OCA_W] <= CA_NC);
    end

endmodule

// File: rtl/tbase_reg.sv
module tbase_reg
    import tbase_pkg::*;
#(
    parameter bit PEND_TABLE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             wr_hi_i,
    input  logic             wr_full_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             lock_i,
    output logic [REG_W-1:0] base_o
);

    localparam logic [REG_W-1:0] RSV = rsv_mask(PEND_TABLE);

    tbase_state_t st_d, st_q;
    logic [REG_W-1:0] merged;
    logic [REG_W-1:0] cleaned;

    tbase_merge merge_i (
        .old_i    (st_q.val),
        .data_i   (wr_data_i),
        .hi_i     (wr_hi_i),
        .full_i   (wr_full_i),
        .merged_o (merged)
    );

    tbase_sanitise #(.PEND_TABLE(PEND_TABLE)) san_i (
        .raw_i   (merged),
        .clean_o (cleaned)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en_i && !lock_i) begin
            st_d.val = cleaned;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_o = st_q.val;

    // R2: a locked write leaves the register untouched
    assert_locked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && lock_i) |=> $stable(base_o));

    // R11: no write, no change
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i) |=> $stable(base_o));

    // R3: an upper-half write keeps the lower half outside the attribute bits
    assert_other_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !lock_i && !wr_full_i && wr_hi_i) |=> $stable(base_o[31:12]));

    // R3: a lower-half write keeps the upper half outside the outer field
    assert_upper_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !lock_i && !wr_full_i && !wr_hi_i) |=> $stable(base_o[55:32]));

    // R6/R10: after an accepted write the inner field is legal
    assert_inner_after_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !lock_i) |=> (base_o[ICA_LO +: ICA_W] > CA_NC));

    // R8/R9: reserved bits stay clear in the stored value
    assert_rsv_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((base_o & RSV) == '0));

    // R5/R7: stored attribute codes are always supported ones
    assert_stored_codes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (base_o[SHR_LO +: SHR_W] != SHR_OUTER) && (base_o[OCA_LO +: OCA_W] <= CA_NC));

endmodule

// File: tb/tbase_reg_tb.sv
module tbase_reg_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_hi = 1'b0;
    logic        wr_full = 1'b0;
    logic [63:0] wr_data = '0;
    logic        lock = 1'b0;
    logic [63:0] prop_o, pend_o;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    tbase_reg #(.PEND_TABLE(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_hi_i(wr_hi),
        .wr_full_i(wr_full), .wr_data_i(wr_data), .lock_i(lock), .base_o(prop_o)
    );

    tbase_reg #(.PEND_TABLE(1'b1)) dut_pend_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_hi_i(wr_hi),
        .wr_full_i(wr_full), .wr_data_i(wr_data), .lock_i(lock), .base_o(pend_o)
    );

    // behavioural reference
    function automatic logic [63:0] ref_clean(input logic [63:0] v, input bit pend);
        logic [63:0] r;
        int s, ic, oc;
        r  = v;
        s  = int'(v[11:10]);
        ic = int'(v[9:7]);
        oc = int'(v[58:56]);
        if (s == 2) s = 1;
        if (ic < 2) ic = 3;
        if (oc > 1) oc = 1;
        r[11:10] = s[1:0];
        r[9:7]   = ic[2:0];
        r[58:56] = oc[2:0];
        for (int b = 0; b < 64; b++) begin
            bit clr;
            clr = (b >= 48 && b <= 55);
            if (pend) clr = clr || b == 63 || (b >= 59 && b <= 61) ||
                            (b >= 12 && b <= 15) || b <= 6;
            else      clr = clr || b >= 59 || b == 5 || b == 6;
            if (clr) r[b] = 1'b0;
        end
        return r;
    endfunction

    function automatic logic [63:0] ref_next(input logic [63:0] cur, input bit pend);
        logic [63:0] m;
        if (!wr_en || lock) return cur;
        m = cur;
        if (wr_full)    m = wr_data;
        else if (wr_hi) m[63:32] = wr_data[31:0];
        else            m[31:0]  = wr_data[31:0];
        return ref_clean(m, pend);
    endfunction

    logic [63:0] exp_prop = '0, exp_pend = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_prop <= '0;
            exp_pend <= '0;
        end else begin
            exp_prop <= ref_next(exp_prop, 1'b0);
            exp_pend <= ref_next(exp_pend, 1'b1);
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check({cur_req, " prop model"}, prop_o, exp_prop);
            check({cur_req, " pend model"}, pend_o, exp_pend);
        end
    end

    task automatic wr(input bit hi, input bit full, input logic [63:0] d, input bit lk,
                      input string req, input logic [63:0] e_prop, input logic [63:0] e_pend);
        @(negedge clk);
        cur_req = req;
        wr_en = 1'b1; wr_hi = hi; wr_full = full; wr_data = d; lock = lk;
        @(negedge clk);
        wr_en = 1'b0; lock = 1'b0;
        check({req, " prop"}, prop_o, e_prop);
        check({req, " pend"}, pend_o, e_pend);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all-reqs actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] lfsr;
        repeat (3) @(negedge clk);
        check("R1 prop", prop_o, 64'h0);
        check("R1 pend", pend_o, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4/R7/R8/R9: full write of all ones
        wr(1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R4",
           64'h0100_FFFF_FFFF_FF9F, 64'h4100_FFFF_FFFF_0F80);
        // R2: locked write dropped
        wr(1'b0, 1'b1, 64'h0, 1'b1, "R2",
           64'h0100_FFFF_FFFF_FF9F, 64'h4100_FFFF_FFFF_0F80);
        // R3/R5/R6: lower half, outer shareable and device inner
        wr(1'b0, 1'b0, 64'hDEAD_BEEF_0000_0800, 1'b0, "R5",
           64'h0100_FFFF_0000_0580, 64'h4100_FFFF_0000_0580);
        // R3/R7: upper half, outer cacheability 3 forced to 1
        wr(1'b1, 1'b0, 64'h0000_0000_0300_0000, 1'b0, "R7",
           64'h0100_0000_0000_0580, 64'h0100_0000_0000_0580);
        // R4: full write ignores half select; R6 inner 1 -> 3
        wr(1'b1, 1'b1, 64'h0000_1234_0000_0480, 1'b0, "R6",
           64'h0000_1234_0000_0580, 64'h0000_1234_0000_0580);
        // R6 pass value 5, R8 vs R9 reserved 15:12
        wr(1'b0, 1'b1, 64'h0100_0000_ABCD_E280, 1'b0, "R9",
           64'h0100_0000_ABCD_E280, 64'h0100_0000_ABCD_0280);
        // R2: locked upper write dropped
        wr(1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R2",
           64'h0100_0000_ABCD_E280, 64'h0100_0000_ABCD_0280);
        // R11: idle cycles hold
        cur_req = "R11";
        repeat (3) @(negedge clk);
        check("R11 prop", prop_o, 64'h0100_0000_ABCD_E280);
        check("R11 pend", pend_o, 64'h0100_0000_ABCD_0280);

        // R10: reset then an upper write fixes lower attributes on the merged word
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        wr(1'b1, 1'b0, 64'h0000_0000_0000_0077, 1'b0, "R10",
           64'h0000_0077_0000_0180, 64'h0000_0077_0000_0180);

        // R8/R9/R10: pseudo-random traffic against the model
        cur_req = "R10";
        lfsr = 64'h1357_9BDF_2468_ACE1;
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            wr_en   = lfsr[3];
            wr_hi   = lfsr[17];
            wr_full = lfsr[29];
            lock    = (lfsr[41] & lfsr[42]);
            wr_data = {lfsr[31:0], lfsr[63:32]} ^ (lfsr << 7);
        end
        @(negedge clk);
        wr_en = 1'b0; lock = 1'b0;
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule